// File: doc/BRIEF.md
# Staged-window transmit message queue

This block queues outgoing CAN frames for a controller's transmit path. Software never addresses queue slots. It composes one frame in a single fixed mailbox window (identifier word, length code, two data words) and then writes a key byte to a pointer register. That write copies the staged frame into the tail of a four-slot ring. The staged contents stay in the window afterwards, so a repeated commit sends the same frame again.

On the far side, a valid/ready frame port hands out the oldest queued frame, and a protocol engine pops it once the frame is on the wire. Software follows progress through a small unsent-message count rather than per-slot flags. A sticky completion flag, gated by an enable bit, raises the interrupt line each time a frame leaves. A bus-off indication throws away everything still pending. Bit timing, arbitration and serialisation belong to the engine behind the frame port.

Top module: `mbx_tx_queue`

## Requirements
- R1: After reset, `unsent` is 0, `tx_valid` is 0, `tx_overflow` is 0, `txdone_flag` is 0, `irq` is 0, and both the queue enable and the interrupt enable are cleared.
- R2: A host write with `host_addr[8]`=0 addresses mailbox `host_addr[7:2]` and field `host_addr[1:0]`. The fields are: 0 identifier (32 bits), 1 length code (`wdata[3:0]`), 2 data bytes 0..3 (byte 0 in bits 7:0), and 3 data bytes 4..7. Only mailbox 56 is the staging window; writes to any other mailbox index leave the staged frame unchanged.
- R3: A host write to control offset 0 (`host_addr`=0x100) with `wdata[7:0]`=0xFF commits the staged frame: a copy goes to the queue tail and `unsent` rises by one on the next cycle. Any other value written there is ignored.
- R4: Bit 0 of control offset 1 enables the queue. A commit written while this bit is 0 has no effect.
- R5: `tx_valid` is high exactly when `unsent` is nonzero, and it presents the oldest committed frame. A cycle with `tx_valid` and `tx_ready` both high removes that frame and lowers `unsent` by one. Frames leave in commit order, and the presented frame holds steady while it is not taken.
- R6: A commit and a pop in the same cycle leave `unsent` unchanged, and both take effect.
- R7: A commit arriving while `unsent` is 4 is dropped, even if a pop happens in the same cycle. It sets `tx_overflow`, which stays set until reset.
- R8: When identifier bit 30 (remote request) of a queued frame is set, `tx_data` reads as zero, whatever data words were staged.
- R9: Each pop sets `txdone_flag` (bit 3 of the interrupt status at control offset 2). Writing offset 2 with bit 3 = 0 clears it, and writing with bit 3 = 1 leaves it unchanged. A pop in the same cycle as a clear wins.
- R10: `irq` equals `txdone_flag` ANDed with bit 3 of the interrupt enable at control offset 3.
- R11: A cycle with `bus_off` high discards every pending frame: `unsent` becomes 0 and `tx_valid` 0 on the next cycle. A commit or pop in that same cycle is ignored, and the next commit is delivered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host write address (mailbox space or control space) |
| host_wdata | input | 32 | Host write data |
| bus_off | input | 1 | Bus-off entry indication, flushes the queue |
| tx_valid | output | 1 | Oldest queued frame is presented |
| tx_ready | input | 1 | Engine takes the presented frame |
| tx_id | output | 32 | Identifier word of the presented frame |
| tx_dlc | output | 4 | Length code of the presented frame |
| tx_data | output | 64 | Data bytes, byte 0 in bits 7:0 |
| unsent | output | 3 | Number of committed frames not yet taken (0..4) |
| tx_overflow | output | 1 | Sticky flag for a dropped commit |
| txdone_flag | output | 1 | Completion status flag |
| irq | output | 1 | Transmit-complete interrupt |

## Verification
The bench sweeps every fill level from one to four frames, each followed by a full drain. This separates counting errors from ordering errors, because each frame carries a distinct identifier, length and data pattern. Further patterns cover stray writes to a neighbouring mailbox, a wrong key byte, commits while disabled, commit plus pop at half fill and at full fill, a fifth commit at full, and a remote-request frame with nonzero staged data. They tell decode faults apart from capacity faults and payload masking faults. A bus-off pulse that coincides with a commit, followed by a fresh frame, distinguishes a real flush from a pointer skew. Clear writes with the flag bit at 1 and at 0, and a clear that races a pop, pin down the flag's write semantics and its priority.

// File: rtl/mbx_txq_pkg.sv
package mbx_txq_pkg;

    localparam int MBX_COUNT   = 64;
    localparam int MBX_IDX_W   = $clog2(MBX_COUNT);
    localparam int FIELD_W     = 2;
    localparam int HOST_AW     = 1 + MBX_IDX_W + FIELD_W;
    localparam int ID_W        = 32;
    localparam int DLC_W       = 4;
    localparam int DATA_BYTES  = 8;
    localparam int DATA_W      = DATA_BYTES * 8;
    localparam int WORD_W      = 32;
    localparam int RTR_BIT     = 30;
    localparam int QEN_BIT     = 0;
    localparam int TXDONE_BIT  = 3;
    localparam logic [7:0] COMMIT_KEY = 8'hFF;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } txq_frame_t;

    typedef enum logic [FIELD_W-1:0] {
        WF_ID      = 2'd0,
        WF_DLC     = 2'd1,
        WF_DATA_LO = 2'd2,
        WF_DATA_HI = 2'd3
    } win_field_e;

    typedef enum logic [FIELD_W-1:0] {
        CR_POINTER = 2'd0,
        CR_QUEUE   = 2'd1,
        CR_ISTAT   = 2'd2,
        CR_IEN     = 2'd3
    } ctl_reg_e;

    // A remote request carries no payload on the wire.
    function automatic txq_frame_t strip_remote(input txq_frame_t f);
        txq_frame_t r;
        r = f;
        if (f.id[RTR_BIT]) r.data = '0;
        return r;
    endfunction

endpackage

// File: rtl/mbx_txq_stage.sv
module mbx_txq_stage
    import mbx_txq_pkg::*;
#(
    parameter int WINDOW_IDX = 56
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mbx_we,
    input  logic [MBX_IDX_W-1:0]  mbx_idx,
    input  logic [FIELD_W-1:0]    field,
    input  logic [WORD_W-1:0]     wdata,
    output txq_frame_t            staged
);

    localparam logic [MBX_IDX_W-1:0] WIN = MBX_IDX_W'(WINDOW_IDX);

    logic       hit;
    win_field_e fsel;

    assign hit  = mbx_we && (mbx_idx == WIN);
    assign fsel = win_field_e'(field);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (hit) begin
            unique case (fsel)
                WF_ID:      staged.id                     <= wdata;
                WF_DLC:     staged.dlc                    <= wdata[DLC_W-1:0];
                WF_DATA_LO: staged.data[WORD_W-1:0]       <= wdata;
                WF_DATA_HI: staged.data[DATA_W-1:WORD_W]  <= wdata;
                default:    staged                        <= staged;
            endcase
        end
    end

endmodule

// File: rtl/mbx_txq_ring.sv
module mbx_txq_ring
    import mbx_txq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              push,
    input  txq_frame_t                        push_frame,
    input  logic                              pop,
    input  logic                              flush,
    output txq_frame_t                        head,
    output logic                              valid,
    output logic [$clog2(DEPTH+1)-1:0]        count,
    output logic                              overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    txq_frame_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, accept, take;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full   = (count == FULL_CNT);
    assign valid  = (count != '0);
    assign accept = push && !full && !flush;
    assign take   = pop && valid && !flush;
    assign head   = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) slots[wr_ptr] <= push_frame;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= step(wr_ptr);
            if (take)   rd_ptr <= step(rd_ptr);
            unique case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          overflow <= 1'b0;
        else if (push && full && !flush)  overflow <= 1'b1;
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0) && !valid);

    p_push_pop_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !full && pop && valid && !flush) |=> count == $past(count));

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: rtl/mbx_txq_ctrl.sv
module mbx_txq_ctrl
    import mbx_txq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_queue,
    input  logic wr_istat,
    input  logic wr_ien,
    input  logic wbit_qen,
    input  logic wbit_done,
    input  logic done_evt,
    output logic queue_en,
    output logic txdone,
    output logic irq
);

    logic done_ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            queue_en <= 1'b0;
            done_ien <= 1'b0;
            txdone   <= 1'b0;
        end else begin
            if (wr_queue) queue_en <= wbit_qen;
            if (wr_ien)   done_ien <= wbit_done;
            if (done_evt)                   txdone <= 1'b1;
            else if (wr_istat && !wbit_done) txdone <= 1'b0;
        end
    end

    assign irq = txdone && done_ien;

    p_done_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> txdone);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> txdone);

endmodule

// File: rtl/mbx_tx_queue.sv
module mbx_tx_queue
    import mbx_txq_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int WINDOW_IDX = 56
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_we,
    input  logic [HOST_AW-1:0]          host_addr,
    input  logic [WORD_W-1:0]           host_wdata,
    input  logic                        bus_off,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [ID_W-1:0]             tx_id,
    output logic [DLC_W-1:0]            tx_dlc,
    output logic [DATA_W-1:0]           tx_data,
    output logic [$clog2(DEPTH+1)-1:0]  unsent,
    output logic                        tx_overflow,
    output logic                        txdone_flag,
    output logic                        irq
);

    localparam int CTL_SEL_BIT = HOST_AW - 1;

    logic       ctl_we, mbx_we, queue_en, commit, pop;
    ctl_reg_e   creg;
    txq_frame_t staged, head;

    assign ctl_we = host_we &&  host_addr[CTL_SEL_BIT];
    assign mbx_we = host_we && !host_addr[CTL_SEL_BIT];
    assign creg   = ctl_reg_e'(host_addr[FIELD_W-1:0]);
    assign commit = ctl_we && (creg == CR_POINTER) && queue_en
                    && (host_wdata[7:0] == COMMIT_KEY);
    assign pop    = tx_valid && tx_ready && !bus_off;

    mbx_txq_stage #(.WINDOW_IDX(WINDOW_IDX)) i_stage (
        .clk     (clk),
        .rst     (rst),
        .mbx_we  (mbx_we),
        .mbx_idx (host_addr[CTL_SEL_BIT-1:FIELD_W]),
        .field   (host_addr[FIELD_W-1:0]),
        .wdata   (host_wdata),
        .staged  (staged)
    );

    mbx_txq_ring #(.DEPTH(DEPTH)) i_ring (
        .clk        (clk),
        .rst        (rst),
        .push       (commit),
        .push_frame (strip_remote(staged)),
        .pop        (pop),
        .flush      (bus_off),
        .head       (head),
        .valid      (tx_valid),
        .count      (unsent),
        .overflow   (tx_overflow)
    );

    mbx_txq_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_queue  (ctl_we && (creg == CR_QUEUE)),
        .wr_istat  (ctl_we && (creg == CR_ISTAT)),
        .wr_ien    (ctl_we && (creg == CR_IEN)),
        .wbit_qen  (host_wdata[QEN_BIT]),
        .wbit_done (host_wdata[TXDONE_BIT]),
        .done_evt  (pop),
        .queue_en  (queue_en),
        .txdone    (txdone_flag),
        .irq       (irq)
    );

    assign tx_id   = head.id;
    assign tx_dlc  = head.dlc;
    assign tx_data = head.data;

    p_head_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !bus_off) |=> tx_valid && $stable(tx_id)
        && $stable(tx_data));

    p_remote_no_data_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_id[RTR_BIT]) |-> (tx_data == '0));

    p_valid_tracks_count_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid == (unsent != '0));

endmodule

// File: tb/test_mbx_tx_queue.sv
module test_mbx_tx_queue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        bus_off = 1'b0;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic [2:0]  unsent;
    logic        tx_overflow, txdone_flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] q_id   [0:63];
    logic [3:0]  q_dlc  [0:63];
    logic [63:0] q_data [0:63];
    int q_head = 0;
    int q_tail = 0;

    localparam logic [8:0] WIN   = 9'h0E0;
    localparam logic [8:0] CTL   = 9'h100;

    always #4 clk = ~clk;

    mbx_tx_queue i_mbx_tx_queue (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .bus_off(bus_off), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .unsent(unsent), .tx_overflow(tx_overflow), .txdone_flag(txdone_flag),
        .irq(irq)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [31:0] pat_id(input int k, input bit rtr);
        logic [31:0] v;
        v = 32'h0100_0000 + 32'(k) * 32'h0001_0305;
        v[30] = rtr;
        return v;
    endfunction

    task automatic stage(input int k, input bit rtr);
        logic [63:0] d;
        d = {32'hA5A5_0000 + 32'(k), 32'h0F00_0000 ^ 32'(k * 7)};
        wr(WIN + 9'd0, pat_id(k, rtr));
        wr(WIN + 9'd1, 32'(k % 9));
        wr(WIN + 9'd2, d[31:0]);
        wr(WIN + 9'd3, d[63:32]);
        q_id[q_tail % 64]   = pat_id(k, rtr);
        q_dlc[q_tail % 64]  = 4'(k % 9);
        q_data[q_tail % 64] = rtr ? 64'd0 : d;
    endtask

    // stage then commit; the entry is expected only if accepted
    task automatic push(input int k, input bit rtr);
        stage(k, rtr);
        wr(CTL, 32'hFF);
        q_tail++;
    endtask

    task automatic take(input string req);
        check({req, " valid"}, 128'(tx_valid), 128'd1);
        check({req, " id"},    128'(tx_id),    128'(q_id[q_head % 64]));
        check({req, " dlc"},   128'(tx_dlc),   128'(q_dlc[q_head % 64]));
        check({req, " data"},  128'(tx_data),  128'(q_data[q_head % 64]));
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        q_head++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 unsent", 128'(unsent), 128'd0);
        check("R1 valid", 128'(tx_valid), 128'd0);
        check("R1 ovf", 128'(tx_overflow), 128'd0);
        check("R1 done", 128'(txdone_flag), 128'd0);
        check("R1 irq", 128'(irq), 128'd0);

        // R4: commit while disabled is ignored
        stage(1, 0);
        wr(CTL, 32'hFF);
        check("R4 disabled commit", 128'(unsent), 128'd0);
        wr(CTL + 9'd1, 32'h1);

        // R2: a write to mailbox 55 must not disturb the window
        stage(2, 0);
        wr(9'h0DC, 32'hDEAD_BEEF);
        wr(9'h0DE, 32'h1234_5678);
        wr(CTL, 32'hFF);
        q_tail++;
        check("R3 commit count", 128'(unsent), 128'd1);
        take("R2 window");

        // R3: wrong key ignored
        wr(CTL, 32'hFE);
        check("R3 wrong key", 128'(unsent), 128'd0);

        // R3 R5 R9: sweep fill levels 1..4 then drain
        for (int n = 1; n <= 4; n++) begin
            for (int j = 0; j < n; j++) begin
                push(10 * n + j, 0);
                check("R3 fill", 128'(unsent), 128'(j + 1));
            end
            for (int j = 0; j < n; j++) begin
                take("R5 order");
                check("R5 drain", 128'(unsent), 128'(n - j - 1));
                check("R9 done", 128'(txdone_flag), 128'd1);
            end
            check("R5 empty", 128'(tx_valid), 128'd0);
        end

        // R9/R10: clear semantics and enable gating
        check("R10 irq masked", 128'(irq), 128'd0);
        wr(CTL + 9'd3, 32'h8);
        check("R10 irq on", 128'(irq), 128'd1);
        wr(CTL + 9'd2, 32'h8);
        check("R9 write one keeps", 128'(txdone_flag), 128'd1);
        wr(CTL + 9'd2, 32'h0);
        check("R9 write zero clears", 128'(txdone_flag), 128'd0);
        check("R10 irq off", 128'(irq), 128'd0);

        // R8: remote request hides payload
        push(77, 1);
        take("R8 remote");

        // R6: commit and pop together at half fill
        push(30, 0);
        push(31, 0);
        stage(32, 0);
        check("R6 head", 128'(tx_id), 128'(q_id[q_head % 64]));
        host_we = 1'b1; host_addr = CTL; host_wdata = 32'hFF; tx_ready = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tx_ready = 1'b0;
        q_head++; q_tail++;
        check("R6 count held", 128'(unsent), 128'd2);
        take("R6 order");
        take("R6 order");

        // R7: fifth commit dropped, overflow sticky
        for (int j = 0; j < 4; j++) push(40 + j, 0);
        check("R7 full", 128'(unsent), 128'd4);
        check("R7 no ovf yet", 128'(tx_overflow), 128'd0);
        stage(49, 0);
        wr(CTL, 32'hFF);
        check("R7 dropped", 128'(unsent), 128'd4);
        check("R7 ovf", 128'(tx_overflow), 128'd1);
        // R7: commit with pop at full still dropped
        check("R7 head", 128'(tx_id), 128'(q_id[q_head % 64]));
        host_we = 1'b1; host_addr = CTL; host_wdata = 32'hFF; tx_ready = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tx_ready = 1'b0;
        q_head++;
        check("R7 full pop", 128'(unsent), 128'd3);
        for (int j = 0; j < 3; j++) take("R7 drain");
        check("R7 empty", 128'(tx_valid), 128'd0);
        check("R7 ovf stays", 128'(tx_overflow), 128'd1);

        // R9: pop racing a clear wins
        push(55, 0);
        wr(CTL + 9'd2, 32'h0);
        host_we = 1'b1; host_addr = CTL + 9'd2; host_wdata = 32'h0; tx_ready = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tx_ready = 1'b0;
        q_head++;
        check("R9 set wins", 128'(txdone_flag), 128'd1);

        // R11: bus-off flush with a coinciding commit
        for (int j = 0; j < 3; j++) push(60 + j, 0);
        check("R11 pre", 128'(unsent), 128'd3);
        stage(66, 0);
        host_we = 1'b1; host_addr = CTL; host_wdata = 32'hFF; bus_off = 1'b1;
        @(negedge clk);
        host_we = 1'b0; bus_off = 1'b0;
        check("R11 flushed", 128'(unsent), 128'd0);
        check("R11 no valid", 128'(tx_valid), 128'd0);
        q_head = q_tail;
        push(70, 0);
        check("R11 restart", 128'(unsent), 128'd1);
        take("R11 fresh frame");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule